// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. When either of two address strobes is asserted, it captures an external word address and three chip-enable inputs on the rising clock edge. A 2-bit beat counter then steps through the other three words of the aligned four-word block. The counter moves only on clocks where the advance input is high. The low two address bits follow an interleaved (XOR) order or a linear wrapping order. The mode input chooses between them at run time.

The captured chip enables decide selection for the whole burst. When the block is deselected, the advance input has no effect until the next strobe. Two outputs report progress through the burst: the current beat index and a selected flag.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge where `strobe_p` or `strobe_c` is high, the block captures `addr_in`. From the next cycle `addr_out` equals the captured address and `beat` is 0.
- R2: `selected` takes the value (`ce_in` == 3'b111) sampled at the strobe edge. Changes of `ce_in` between strobes have no effect.
- R3: With `mode` high, the low two bits of `addr_out` equal the captured low bits XOR `beat`.
- R4: With `mode` low, the low two bits equal the captured low bits plus `beat`, modulo 4. The upper bits of `addr_out` stay at the captured value for the whole burst.
- R5: Without a strobe, `beat` increments by one on an edge only when `adv` is high and `selected` is high. Otherwise it holds.
- R6: While `selected` is low, `adv` is ignored: `beat` and `addr_out` hold.
- R7: A strobe in the middle of a burst restarts the burst at the new address with `beat` 0.
- R8: During reset, `selected` is 0, `beat` is 0 and `addr_out` is 0.
- R9: Asserting both strobes on the same edge has the same effect as asserting one of them alone.
- R10: `beat` wraps from 3 to 0 on the next advance, which returns `addr_out` to the first address of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | AW | External word address |
| ce_in | input | 3 | Chip enables; all high selects |
| strobe_p | input | 1 | Processor-side address strobe |
| strobe_c | input | 1 | Controller-side address strobe |
| adv | input | 1 | Advance burst by one beat |
| mode | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_out | output | AW | Current burst word address |
| selected | output | 1 | Captured selection state |
| beat | output | 2 | Beat index within the burst |

## Verification
The bench builds the block with AW = 5. This makes every starting address reachable, so every upper-bit value and all four low-bit starts are swept in both burst orders. Each burst interleaves stalls with advances and runs past the wrap point. A further sweep strobes with all eight chip-enable patterns, then toggles `adv` and `ce_in`. Bursts restarted in mid-flight and bursts loaded by both strobes at once are also covered.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic [2:0]    ce_in,
  input  logic          strobe_p,
  input  logic          strobe_c,
  input  logic          adv,
  input  logic          mode,
  output logic [AW-1:0] addr_out,
  output logic          selected,
  output logic [1:0]    beat
);

  logic [AW-3:0] base_q;
  logic [1:0]    start_q;
  logic [1:0]    cnt_q;
  logic          sel_q;
  logic [1:0]    low;
  logic          load;

  assign load = strobe_p | strobe_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
    end else if (load) begin
      base_q  <= addr_in[AW-1:2];
      start_q <= addr_in[1:0];
      cnt_q   <= '0;
      sel_q   <= &ce_in;
    end else if (sel_q && adv) begin
      cnt_q   <= cnt_q + 2'd1;
    end
  end

  assign low      = mode ? (start_q ^ cnt_q) : (start_q + cnt_q);
  assign addr_out = {base_q, low};
  assign selected = sel_q;
  assign beat     = cnt_q;

  assert_load_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_out == $past(addr_in)) && (beat == 2'd0));

  assert_select_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> selected == ($past(ce_in) == 3'b111));

  assert_select_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(selected));

  assert_upper_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_out[AW-1:2]));

  assert_advance_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv && selected) |=> beat == $past(beat) + 2'd1);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(beat));

  assert_deselect_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !selected) |=> $stable(beat));

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic [2:0]    ce_in;
  logic          strobe_p, strobe_c, adv, mode;
  logic [AW-1:0] addr_out;
  logic          selected;
  logic [1:0]    beat;

  int checks = 0;
  int fails  = 0;

  logic [AW-1:0] m_addr;
  logic [1:0]    m_cnt;
  logic          m_sel;

  always #10 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ce_in(ce_in),
    .strobe_p(strobe_p), .strobe_c(strobe_c), .adv(adv), .mode(mode),
    .addr_out(addr_out), .selected(selected), .beat(beat)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = mode ? (m_addr[1:0] ^ m_cnt) : (m_addr[1:0] + m_cnt);
    return {m_addr[AW-1:2], lo};
  endfunction

  task automatic check(input string req);
    checks++;
    if (addr_out !== exp_addr() || beat !== m_cnt || selected !== m_sel) begin
      fails++;
      $display("FAIL %s: addr=%0d beat=%0d sel=%0d expected addr=%0d beat=%0d sel=%0d",
               req, addr_out, beat, selected, exp_addr(), m_cnt, m_sel);
    end
  endtask

  task automatic cyc(input logic sp, input logic sc, input logic a, input logic [2:0] ce,
                     input logic [AW-1:0] ad, input string req);
    @(negedge clk);
    strobe_p = sp; strobe_c = sc; adv = a; ce_in = ce; addr_in = ad;
    @(posedge clk);
    if (sp || sc) begin
      m_addr = ad; m_cnt = 2'd0; m_sel = (ce == 3'b111);
    end else if (m_sel && a) begin
      m_cnt = m_cnt + 2'd1;
    end
    #2;
    check(req);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe_p = 0; strobe_c = 0; adv = 0; mode = 0;
    ce_in = 3'b111; addr_in = '0;
    m_addr = '0; m_cnt = 0; m_sel = 0;
    repeat (3) @(posedge clk);
    #2 check("R8 reset");
    @(negedge clk) rst_n = 1'b1;

    for (int m = 0; m < 2; m++) begin
      mode = m[0];
      for (int a = 0; a < (1 << AW); a++) begin
        cyc(a[0], a[1] | ~a[0], 1'b0, 3'b111, a[AW-1:0], m[0] ? "R1 R3 load" : "R1 R4 load");
        for (int k = 0; k < 5; k++) begin
          cyc(0, 0, 1'b1, 3'b111, ~a[AW-1:0], m[0] ? "R3 interleaved beat" : "R4 linear beat");
          if (k == 1) cyc(0, 0, 1'b0, 3'b000, '0, "R5 stall");
        end
        cyc(0, 0, 1'b0, 3'b111, '0, "R10 wrap hold");
      end
    end

    for (int c = 0; c < 8; c++) begin
      cyc(1, 0, 0, c[2:0], 5'd13, "R2 capture ce");
      cyc(0, 0, 1, ~c[2:0], 5'd0, "R6 advance while deselected");
      cyc(0, 0, 1, 3'b111, 5'd7, "R2 ce ignored between strobes");
      cyc(0, 0, 1, 3'b000, 5'd7, "R6 ignore adv");
    end

    mode = 1'b0;
    cyc(1, 0, 0, 3'b111, 5'd6, "R1 load");
    cyc(0, 0, 1, 3'b111, 5'd0, "R5 advance");
    cyc(0, 0, 1, 3'b111, 5'd0, "R5 advance");
    cyc(0, 1, 1, 3'b111, 5'd25, "R7 restart mid burst");
    cyc(0, 0, 1, 3'b111, 5'd0, "R7 after restart");
    cyc(1, 1, 1, 3'b111, 5'd18, "R9 both strobes");
    cyc(0, 0, 1, 3'b111, 5'd0, "R9 following beat");
    mode = 1'b1;
    #1 check("R3 live mode switch");
    cyc(1, 1, 0, 3'b011, 5'd31, "R9 both strobes deselect");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule